// File: doc/BRIEF.md
# Signed integer to binary64 converter

This block is the integer-to-double conversion lane of a floating-point execution unit. It takes a 32-bit instruction word and a 64-bit raw register image. It decodes the word, and if the word selects the conversion, it treats the register image as a two's-complement integer and produces the IEEE-754 binary64 value of that integer. The result is rounded under a 2-bit rounding-mode control input.

Each accepted operation also produces its status side effects. These are a fraction-rounded flag and an inexact-fraction flag, a sticky inexact flag and a sticky exception summary, and a 5-bit result-class code. When the instruction's record bit is set, the block also drives a 4-bit condition field copied from the status bits.

The block presents the source register index combinationally, so the register file can supply the operand in the same cycle. One stage of output registers sits behind a valid/ready handshake, and results appear one clock after acceptance.

Top module: `i2d_convert`

## Requirements
- R1: An instruction word is accepted as this operation only when bits [31:26] equal 63, bits [10:1] equal 846 and the unused A field bits [20:16] are zero. The source index is bits [15:11], the destination index is bits [25:21], and the record bit is bit [0]. A word that does not match is consumed and produces no output and no status change.
- R2: The operand is a two's-complement integer. Every value of magnitude at most 2^53 converts exactly, with both fraction flags clear.
- R3: The rounding-mode input selects the rounding: 00 is nearest-even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity.
- R4: When rounding carries out of the 53-bit significand, the exponent is incremented. For example, 2^63-1 converts under nearest-even to 2^63 (0x43E0000000000000).
- R5: The most negative integer, -2^63, converts exactly to 0xC3E0000000000000 with no inexact indication.
- R6: A zero operand yields +0.0, which is all 64 result bits zero.
- R7: No result is infinity or NaN. The biased exponent field [62:52] is never all ones.
- R8: out_fi is 1 when the result is inexact. out_fr is 1 when rounding increased the significand magnitude. Both are 0 for an exact result.
- R9: out_xx and out_fx are sticky. Both become 1 on any inexact conversion and are cleared only by reset.
- R10: out_fprf is 00010 for +zero, 00100 for a positive result and 01000 for a negative result.
- R11: With the record bit set, out_cr_en is 1 and out_cr holds {FX, FEX, VX, OX} in bits 3 down to 0. FX is the updated sticky summary, and the other three bits are 0 because this operation never raises them. With the record bit clear, out_cr_en and out_cr are 0.
- R12: in_ready equals (!out_valid || out_ready). An accepted operation appears on the outputs at the next clock edge, and outputs stay stable while out_valid is held with out_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand present |
| in_ready | output | 1 | Block can accept this cycle |
| in_instr | input | 32 | Instruction word |
| src_idx | output | 5 | Source register index decoded from in_instr |
| in_operand | input | 64 | Raw register image of the source |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | binary64 result |
| out_dst | output | 5 | Destination register index |
| out_fr | output | 1 | Fraction was rounded up |
| out_fi | output | 1 | Result is inexact |
| out_xx | output | 1 | Sticky inexact flag |
| out_fx | output | 1 | Sticky exception summary |
| out_fprf | output | 5 | Result-class code |
| out_cr_en | output | 1 | Condition field is written |
| out_cr | output | 4 | Condition field {FX, FEX, VX, OX} |

## Verification
The bench builds the block with its default parameters: a 64-bit integer, a 52-bit fraction and an 11-bit exponent. These widths expose the real boundaries of the conversion. They cover the exact/inexact edge at 2^53 and 2^53+1, ties and non-ties in each rounding mode, the significand carry at 2^63-1, and the asymmetric extreme -2^63. A behavioural remainder-based model predicts each result. For nearest-even, the host's own integer-to-real conversion gives a second, independent prediction. Sticky flags are tracked across a reset, and the handshake is compared on every clock, including a stall under backpressure.

// File: rtl/i2d_pkg.sv
package i2d_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;

    typedef struct packed {
        logic fx;
        logic fex;
        logic vx;
        logic ox;
        logic xx;
    } fpstat_t;

    typedef struct packed {
        logic       hit;
        logic       record;
        logic [4:0] dst;
        logic [4:0] src;
    } dec_t;

    localparam logic [5:0] OPC_PRIMARY = 6'd63;
    localparam logic [9:0] OPC_EXT     = 10'd846;

    localparam logic [4:0] CLASS_PZERO = 5'b00010;
    localparam logic [4:0] CLASS_PNORM = 5'b00100;
    localparam logic [4:0] CLASS_NNORM = 5'b01000;

    function automatic logic round_up(rmode_e rm, logic sign, logic lsb,
                                      logic guard, logic sticky);
        logic lost;
        lost = guard | sticky;
        case (rm)
            RM_NEAR: round_up = guard & (sticky | lsb);
            RM_ZERO: round_up = 1'b0;
            RM_PINF: round_up = lost & ~sign;
            RM_NINF: round_up = lost & sign;
            default: round_up = 1'b0;
        endcase
    endfunction

    function automatic logic [4:0] class_of(logic sign, logic is_zero);
        if (is_zero)   class_of = CLASS_PZERO;
        else if (sign) class_of = CLASS_NNORM;
        else           class_of = CLASS_PNORM;
    endfunction

endpackage

// File: rtl/i2d_decode.sv
module i2d_decode
    import i2d_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic opc_ok;
    logic ext_ok;
    logic ra_ok;

    assign opc_ok = (instr[31:26] == OPC_PRIMARY);
    assign ext_ok = (instr[10:1] == OPC_EXT);
    assign ra_ok  = (instr[20:16] == 5'd0);

    assign dec.hit    = opc_ok && ext_ok && ra_ok;
    assign dec.record = instr[0];
    assign dec.dst    = instr[25:21];
    assign dec.src    = instr[15:11];
endmodule

// File: rtl/i2d_norm.sv
module i2d_norm #(
    parameter  int W    = 64,
    localparam int LZ_W = $clog2(W)
) (
    input  logic [W-1:0]    operand,
    output logic            sign,
    output logic            is_zero,
    output logic [LZ_W-1:0] lz,
    output logic [W-1:0]    aligned
);
    logic [W-1:0] mag;
    logic         found;

    assign sign    = operand[W-1];
    assign mag     = sign ? (~operand + 1'b1) : operand;
    assign is_zero = (operand == '0);

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && mag[i]) begin
                lz    = LZ_W'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

    assign aligned = mag << lz;
endmodule

// File: rtl/i2d_round.sv
module i2d_round
    import i2d_pkg::*;
#(
    parameter  int W      = 64,
    parameter  int FRAC_W = 52,
    parameter  int EXP_W  = 11,
    localparam int LZ_W   = $clog2(W),
    localparam int SIG_W  = FRAC_W + 1,
    localparam int LOW_W  = W - SIG_W,
    localparam int RES_W  = 1 + EXP_W + FRAC_W
) (
    input  rmode_e           rmode,
    input  logic             sign,
    input  logic             is_zero,
    input  logic [LZ_W-1:0]  lz,
    input  logic [W-1:0]     aligned,
    output logic [RES_W-1:0] result,
    output logic             inexact,
    output logic             frac_up
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [SIG_W-1:0]  sig;
    logic              guard;
    logic              sticky;
    logic [SIG_W:0]    sig_rnd;
    logic              carry;
    logic [EXP_W-1:0]  exp_b;
    logic [FRAC_W-1:0] frac;

    assign sig     = aligned[W-1 -: SIG_W];
    assign guard   = aligned[LOW_W-1];
    assign sticky  = |aligned[LOW_W-2:0];
    assign inexact = guard | sticky;
    assign frac_up = round_up(rmode, sign, sig[0], guard, sticky);

    assign sig_rnd = {1'b0, sig} + (SIG_W + 1)'(frac_up);
    assign carry   = sig_rnd[SIG_W];
    assign exp_b   = EXP_W'(BIAS + W - 1) - EXP_W'(lz) + EXP_W'(carry);
    assign frac    = carry ? '0 : sig_rnd[FRAC_W-1:0];
    assign result  = is_zero ? '0 : {sign, exp_b, frac};

    // R4: after rounding, either the hidden bit survives or it moved into the carry
    always_comb begin
        a_r4_hidden_bit: assert (is_zero || carry || sig_rnd[FRAC_W]);
    end
endmodule

// File: rtl/i2d_convert.sv
module i2d_convert
    import i2d_pkg::*;
#(
    parameter  int W      = 64,
    parameter  int FRAC_W = 52,
    parameter  int EXP_W  = 11,
    localparam int LZ_W   = $clog2(W),
    localparam int RES_W  = 1 + EXP_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_instr,
    output logic [4:0]       src_idx,
    input  logic [W-1:0]     in_operand,
    input  logic [1:0]       in_rmode,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [RES_W-1:0] out_result,
    output logic [4:0]       out_dst,
    output logic             out_fr,
    output logic             out_fi,
    output logic             out_xx,
    output logic             out_fx,
    output logic [4:0]       out_fprf,
    output logic             out_cr_en,
    output logic [3:0]       out_cr
);
    dec_t             dec;
    logic             sign;
    logic             is_zero;
    logic [LZ_W-1:0]  lz;
    logic [W-1:0]     aligned;
    logic [RES_W-1:0] res;
    logic             inexact;
    logic             frac_up;
    logic             fire;
    logic             take;
    fpstat_t          stat_q;
    fpstat_t          stat_nxt;

    i2d_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    i2d_norm #(.W(W)) u_norm (
        .operand (in_operand),
        .sign    (sign),
        .is_zero (is_zero),
        .lz      (lz),
        .aligned (aligned)
    );

    i2d_round #(.W(W), .FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_round (
        .rmode   (rmode_e'(in_rmode)),
        .sign    (sign),
        .is_zero (is_zero),
        .lz      (lz),
        .aligned (aligned),
        .result  (res),
        .inexact (inexact),
        .frac_up (frac_up)
    );

    assign src_idx  = dec.src;
    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;
    assign take     = fire && dec.hit;

    always_comb begin
        stat_nxt    = stat_q;
        stat_nxt.xx = stat_q.xx | inexact;
        stat_nxt.fx = stat_q.fx | inexact;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_dst    <= '0;
            out_fr     <= 1'b0;
            out_fi     <= 1'b0;
            out_fprf   <= '0;
            out_cr_en  <= 1'b0;
            out_cr     <= '0;
            stat_q     <= '0;
        end else if (take) begin
            out_valid  <= 1'b1;
            out_result <= res;
            out_dst    <= dec.dst;
            out_fr     <= frac_up;
            out_fi     <= inexact;
            out_fprf   <= class_of(sign, is_zero);
            out_cr_en  <= dec.record;
            out_cr     <= dec.record ? {stat_nxt.fx, stat_nxt.fex, stat_nxt.vx, stat_nxt.ox} : 4'd0;
            stat_q     <= stat_nxt;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    assign out_xx = stat_q.xx;
    assign out_fx = stat_q.fx;

    a_r12_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_fprf)));

    a_r1_foreign_word: assert property (@(posedge clk) disable iff (rst)
        (fire && !dec.hit && !out_valid) |=> !out_valid);

    a_r9_sticky_fx: assert property (@(posedge clk) disable iff (rst)
        out_fx |=> out_fx);

    a_r8_fr_needs_fi: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fr) |-> out_fi);

    a_r9_fi_sets_sticky: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fi) |-> (out_fx && out_xx));

    a_r7_finite: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result[RES_W-2 -: EXP_W] != '1));

    a_r10_zero_class: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result == '0) |-> (out_fprf == CLASS_PZERO));

    a_r11_cr_copy: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cr_en) |-> (out_cr[3] == out_fx));
endmodule

// File: tb/i2d_convert_tb.sv
`timescale 1ns/1ps
module i2d_convert_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic [4:0]  src_idx;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    logic [4:0]  out_dst;
    logic        out_fr, out_fi, out_xx, out_fx, out_cr_en;
    logic [4:0]  out_fprf;
    logic [3:0]  out_cr;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_sticky = 1'b0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    i2d_convert dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .src_idx(src_idx), .in_operand(in_operand),
        .in_rmode(in_rmode), .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_dst(out_dst), .out_fr(out_fr),
        .out_fi(out_fi), .out_xx(out_xx), .out_fx(out_fx),
        .out_fprf(out_fprf), .out_cr_en(out_cr_en), .out_cr(out_cr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] rb,
                                       input logic rc);
        return {6'd63, rt, 5'd0, rb, 10'd846, rc};
    endfunction

    // Behavioural model: quotient and remainder at the 53-bit cut
    function automatic void ref_cvt(input logic [63:0] x, input logic [1:0] rm,
                                    output logic [63:0] r, output bit inex, output bit up);
        logic        s;
        logic [63:0] m, q, rem, half, sig;
        int          msb, e, sh;
        s = x[63];
        m = s ? -x : x;
        inex = 1'b0;
        up = 1'b0;
        if (m == 64'd0) begin
            r = 64'd0;
            return;
        end
        msb = 0;
        for (int i = 0; i < 64; i++) if (m[i]) msb = i;
        e = msb;
        if (msb <= 52) begin
            sig = m << (52 - msb);
        end else begin
            sh   = msb - 52;
            q    = m >> sh;
            rem  = m & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
            inex = (rem != 64'd0);
            case (rm)
                2'b00: up = (rem > half) || (rem == half && q[0]);
                2'b01: up = 1'b0;
                2'b10: up = inex && !s;
                default: up = inex && s;
            endcase
            sig = q + {63'd0, up};
            if (sig[53]) begin
                sig = sig >> 1;
                e = e + 1;
            end
        end
        r = {s, 11'(e + 1023), sig[51:0]};
    endfunction

    task automatic send(input logic [31:0] ins, input logic [63:0] x, input logic [1:0] rm);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = ins;
        in_operand = x;
        in_rmode = rm;
        #1;
        chk("R1", "source index", 64'(src_idx), 64'(ins[15:11]));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic conv(input string req, input logic [63:0] x, input logic [1:0] rm,
                        input logic rc, input logic [4:0] rt);
        logic [63:0] r;
        bit          inex, up;
        logic [4:0]  cls;
        longint      sx;
        real         rv;
        ref_cvt(x, rm, r, inex, up);
        m_sticky = m_sticky | inex;
        cls = (x == 64'd0) ? 5'b00010 : (x[63] ? 5'b01000 : 5'b00100);
        send(mk(rt, 5'd7, rc), x, rm);
        chk(req, "valid", 64'(out_valid), 64'd1);
        chk(req, "result", out_result, r);
        chk("R8", "fi", 64'(out_fi), 64'(inex));
        chk("R8", "fr", 64'(out_fr), 64'(up));
        chk("R9", "xx", 64'(out_xx), 64'(m_sticky));
        chk("R9", "fx", 64'(out_fx), 64'(m_sticky));
        chk("R10", "class", 64'(out_fprf), 64'(cls));
        chk("R1", "dst", 64'(out_dst), 64'(rt));
        chk("R11", "cr_en", 64'(out_cr_en), 64'(rc));
        chk("R11", "cr", 64'(out_cr), rc ? 64'({m_sticky, 3'b000}) : 64'd0);
        chk("R7", "finite", 64'(out_result[62:52] == 11'h7FF), 64'd0);
        if (rm == 2'b00) begin
            sx = x;
            rv = real'(sx);
            chk("R3", "nearest vs host", out_result, $realtobits(rv));
        end
    endtask

    // Per-clock comparison of the handshake relation
    always begin
        @(posedge clk);
        #1;
        if (!rst && !done)
            chk("R12", "in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [63:0] v;
        logic [63:0] p53;
        p53 = 64'h0020_0000_0000_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "reset valid", 64'(out_valid), 64'd0);
        chk("R9", "reset fx", 64'(out_fx), 64'd0);
        chk("R12", "reset ready", 64'(in_ready), 64'd1);

        conv("R6", 64'd0, 2'b00, 1'b1, 5'd1);
        chk("R6", "plus zero", out_result, 64'd0);
        conv("R2", 64'd1, 2'b00, 1'b0, 5'd2);
        chk("R2", "one", out_result, 64'h3FF0_0000_0000_0000);
        conv("R2", '1, 2'b11, 1'b1, 5'd3);
        chk("R2", "minus one", out_result, 64'hBFF0_0000_0000_0000);
        conv("R2", p53, 2'b10, 1'b0, 5'd4);
        chk("R2", "2^53", out_result, 64'h4340_0000_0000_0000);
        conv("R2", -p53, 2'b00, 1'b0, 5'd5);
        conv("R5", 64'h8000_0000_0000_0000, 2'b00, 1'b1, 5'd6);
        chk("R5", "min int", out_result, 64'hC3E0_0000_0000_0000);
        chk("R5", "min int exact", 64'(out_xx), 64'd0);

        conv("R3", p53 + 1, 2'b00, 1'b1, 5'd8);
        chk("R3", "tie to even", out_result, 64'h4340_0000_0000_0000);
        conv("R3", p53 + 3, 2'b00, 1'b0, 5'd9);
        chk("R3", "tie up to even", out_result, 64'h4340_0000_0000_0002);
        conv("R3", p53 + 1, 2'b01, 1'b0, 5'd10);
        conv("R3", p53 + 1, 2'b10, 1'b0, 5'd11);
        chk("R3", "toward +inf", out_result, 64'h4340_0000_0000_0001);
        conv("R3", p53 + 1, 2'b11, 1'b0, 5'd12);
        conv("R3", -(p53 + 1), 2'b11, 1'b1, 5'd13);
        chk("R3", "neg toward -inf", out_result, 64'hC340_0000_0000_0001);
        conv("R3", -(p53 + 1), 2'b10, 1'b0, 5'd14);
        conv("R4", 64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 5'd15);
        chk("R4", "carry exponent", out_result, 64'h43E0_0000_0000_0000);
        conv("R4", 64'h7FFF_FFFF_FFFF_FFFF, 2'b01, 1'b1, 5'd16);
        conv("R9", 64'd5, 2'b00, 1'b1, 5'd17);
        chk("R9", "sticky after exact", 64'(out_xx), 64'd1);

        v = 64'h1234_5678_9ABC_DEF1;
        for (int i = 0; i < 24; i++) begin
            v = v * 64'd6364136223846793005 + 64'd1442695040888963407;
            conv("R3", v >> (i % 16), 2'(i), 1'(i), 5'(i));
        end

        // R1: foreign words are consumed silently
        @(negedge clk);
        send(32'h7C00_069C, 64'd9, 2'b00);
        chk("R1", "wrong primary", 64'(out_valid), 64'd0);
        send({6'd63, 5'd1, 5'd0, 5'd2, 10'd845, 1'b0}, 64'd9, 2'b00);
        chk("R1", "wrong extended", 64'(out_valid), 64'd0);
        send({6'd63, 5'd1, 5'd3, 5'd2, 10'd846, 1'b0}, 64'd9, 2'b00);
        chk("R1", "nonzero A field", 64'(out_valid), 64'd0);

        // R12: backpressure
        out_ready = 1'b0;
        send(mk(5'd20, 5'd1, 1'b0), 64'd3, 2'b00);
        chk("R12", "held result", out_result, 64'h4008_0000_0000_0000);
        in_valid = 1'b1;
        in_instr = mk(5'd21, 5'd1, 1'b0);
        in_operand = 64'd4;
        #1;
        chk("R12", "stalled ready", 64'(in_ready), 64'd0);
        @(negedge clk);
        chk("R12", "stall valid", 64'(out_valid), 64'd1);
        chk("R12", "stall stable", out_result, 64'h4008_0000_0000_0000);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12", "next after stall", out_result, 64'h4010_0000_0000_0000);
        chk("R12", "next dst", 64'(out_dst), 64'd21);

        // R9: only reset clears the sticky flags
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_sticky = 1'b0;
        @(negedge clk);
        chk("R9", "cleared xx", 64'(out_xx), 64'd0);
        chk("R9", "cleared fx", 64'(out_fx), 64'd0);
        conv("R11", 64'd7, 2'b00, 1'b1, 5'd30);
        chk("R11", "cr clear", 64'(out_cr), 64'd0);

        @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule